// File: doc/BRIEF.md
# Host serial-port register bridge

This block presents a host computer with the register set of a classic byte-wide serial port. No serial line sits behind those registers. Their far side is an embedded controller. The host reaches the registers over an 8-bit parallel bus with active-low read and write strobes, an active-low address enable and a 3-bit register offset.

The controller loads received characters into a receive queue. Each character may carry parity, framing and break tags. The controller drains a transmit queue filled by the host. It also sees the host's terminal-ready and request-to-send settings as two active-low pins.

The block keeps both queues, the line status register, the modem-control bits and a single interrupt line. Queue depth is a parameter of 16. At reset the block is in character mode, where each queue holds one byte. Setting the mode bit selects queue mode, where each queue holds DEPTH bytes.

Top module: `uhb_bridge`

## Requirements
- R1: After reset the status register (offset 5) reads 60h, the modem-control register (offset 4) reads 00h, the interrupt is low, no transmit byte is offered and both controller handshake pins are high.
- R2: At offset 4, bit 0 is terminal-ready and bit 1 is request-to-send, and bits 7..2 read 0. When a bit is set its controller pin is driven low, and when it is clear the pin is driven high.
- R3: A host access is taken only when the address enable is low. An access happens once per strobe assertion: a strobe held low for several cycles pops or pushes only one byte.
- R4: A host write to offset 0 adds a byte to the transmit queue. The controller pops bytes in write order. A write to a full queue is dropped. The queue holds 1 byte in character mode and DEPTH bytes in queue mode.
- R5: Status bit 5 (holding empty) and bit 6 (transmitter empty) both read 1 exactly when the transmit queue is empty.
- R6: A host read of offset 0 returns the oldest received byte and removes it from the queue. A read of an empty queue returns 00h. Status bit 0 is 1 whenever the receive queue is not empty.
- R7: A controller push into a full receive queue replaces the most recently pushed entry, leaves the other entries unchanged and sets status bit 1 (overrun).
- R8: Push tags rx_pe_i, rx_fe_i and rx_bi_i appear as status bits 2, 3 and 4. A tag appears once its character becomes the oldest entry, and stays set until the status register is read. That character's tags are not shown again after the read.
- R9: In queue mode, status bit 7 is 1 while any tagged character is queued. An LSR read clears it once no tagged characters remain. In character mode, bit 7 reads 0.
- R10: Bit 0 of offset 2 selects queue mode (reset 0). Any write to offset 2 empties both queues.
- R11: At offset 1, bit 1 enables an interrupt while the transmit queue is empty, and bit 2 enables an interrupt while any of status bits 1..4 is set.
- R12: A status read clears bits 1..4 on the clock edge that completes the read. An overrun arriving on that same edge is kept and shows on the next read. Writes to offset 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_ior_ni | input | 1 | Host read strobe, active low |
| host_iow_ni | input | 1 | Host write strobe, active low |
| host_aen_ni | input | 1 | Host address enable, active low |
| host_addr_i | input | 3 | Register offset |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data, valid while read strobe and enable are low |
| host_irq_o | output | 1 | Interrupt request, active high |
| ctl_rx_push_i | input | 1 | Controller pushes one received byte |
| ctl_rx_data_i | input | 8 | Received byte |
| ctl_rx_pe_i | input | 1 | Parity tag for the pushed byte |
| ctl_rx_fe_i | input | 1 | Framing tag for the pushed byte |
| ctl_rx_bi_i | input | 1 | Break tag (line held at spacing for over one character time) |
| ctl_tx_pop_i | input | 1 | Controller takes the offered transmit byte |
| ctl_tx_data_o | output | 8 | Oldest transmit byte |
| ctl_tx_valid_o | output | 1 | Transmit queue holds a byte |
| ctl_dtr_no | output | 1 | Terminal-ready pin, active low |
| ctl_rts_no | output | 1 | Request-to-send pin, active low |

## Verification
The assertions rely on a well-formed host bus. Each strobe is sampled at the clock, so it is treated as already synchronous. Offset and write data are taken as steady for the whole time the strobe is low, and the read and write strobes are never low together. The bench changes every input only at falling clock edges. It releases each strobe for at least one rising edge between accesses and never asserts both strobes. A controller push or pop is held for one cycle only, which is the single-cycle handshake the queue and status logic expect.

// File: rtl/uhb_pkg.sv
package uhb_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
    localparam logic [OFS_W-1:0] OFS_MODE  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_MCTL  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;

    typedef struct packed {
        logic              bi;
        logic              fe;
        logic              pe;
        logic [BYTE_W-1:0] data;
    } rx_ent_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [OFS_W-1:0]  ofs;
        logic [BYTE_W-1:0] wdata;
    } host_op_t;
endpackage

// File: rtl/uhb_host_if.sv
module uhb_host_if
    import uhb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ior_ni,
    input  logic              iow_ni,
    input  logic              aen_ni,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output host_op_t          op_o
);
    typedef struct packed {
        logic ior_prev;
        logic iow_prev;
    } strb_st_t;

    strb_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.ior_prev = ior_ni;
        st_d.iow_prev = iow_ni;
        op_o.rd       = !ior_ni && st_q.ior_prev && !aen_ni;
        op_o.wr       = !iow_ni && st_q.iow_prev && !aen_ni;
        op_o.ofs      = addr_i;
        op_o.wdata    = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{ior_prev: 1'b1, iow_prev: 1'b1};
        else         st_q <= st_d;
    end

    // R3: a held strobe yields a single access
    a_r3_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_o.rd |=> !op_o.rd) else $error("R3 repeated read");
    a_r3_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_o.wr |=> !op_o.wr) else $error("R3 repeated write");
endmodule

// File: rtl/uhb_fifo.sv
module uhb_fifo #(
    parameter int unsigned W         = 8,
    parameter int unsigned DEPTH     = 16,
    parameter bit          OVERWRITE = 1'b0,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned CW       = AW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic [CW-1:0] cap_i,
    input  logic          push_i,
    input  logic [W-1:0]  din_i,
    input  logic          pop_i,
    output logic [W-1:0]  head_o,
    output logic [W-1:0]  last_o,
    output logic          empty_o,
    output logic          full_o,
    output logic [CW-1:0] count_o,
    output logic          pushed_o,
    output logic          popped_o,
    output logic          ovw_o
);
    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] count;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic          full_w, pop_w, push_w, ovw_w;
    logic [AW-1:0] last_idx;

    always_comb begin
        full_w   = st_q.count >= cap_i;
        pop_w    = pop_i && (st_q.count != '0) && !flush_i;
        push_w   = push_i && (!full_w || pop_w) && !flush_i;
        last_idx = st_q.wr_ptr - AW'(1);
    end

    generate
        if (OVERWRITE) begin : g_ovw
            assign ovw_w = push_i && full_w && !pop_w && (st_q.count != '0) && !flush_i;
        end else begin : g_drop
            assign ovw_w = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (push_w) st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            if (pop_w)  st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            case ({push_w, pop_w})
                2'b10:   st_d.count = st_q.count + CW'(1);
                2'b01:   st_d.count = st_q.count - CW'(1);
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_ff @(posedge clk_i) begin
        if (push_w)     mem_q[st_q.wr_ptr] <= din_i;
        else if (ovw_w) mem_q[last_idx]    <= din_i;
    end

    assign head_o   = mem_q[st_q.rd_ptr];
    assign last_o   = mem_q[last_idx];
    assign empty_o  = (st_q.count == '0);
    assign full_o   = full_w;
    assign count_o  = st_q.count;
    assign pushed_o = push_w;
    assign popped_o = pop_w;
    assign ovw_o    = ovw_w;

    // R4 / R7: a push into a full queue never grows it
    a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i && full_o && !pop_i && !flush_i |=> $stable(st_q.count))
        else $error("R4 queue grew past capacity");
    // R6: a lone pop removes exactly one entry
    a_r6_pop_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop_i && !empty_o && !push_i && !flush_i |=> st_q.count == $past(st_q.count) - CW'(1))
        else $error("R6 pop count");
endmodule

// File: rtl/uhb_lsr.sv
module uhb_lsr #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic          fifo_mode_i,
    input  logic          lsr_rd_i,
    input  logic          rx_valid_i,
    input  logic [CW-1:0] rx_count_i,
    input  logic [2:0]    head_tags_i,
    input  logic [2:0]    in_tags_i,
    input  logic [2:0]    last_tags_i,
    input  logic          rx_pushed_i,
    input  logic          rx_popped_i,
    input  logic          rx_ovw_i,
    input  logic          tx_empty_i,
    input  logic          ier_thre_i,
    input  logic          ier_rls_i,
    output logic [7:0]    lsr_o,
    output logic          irq_o
);
    typedef struct packed {
        logic          oe;
        logic          pe;
        logic          fe;
        logic          bi;
        logic          sum;
        logic          rep;
        logic [CW-1:0] err_cnt;
    } lsr_st_t;

    lsr_st_t st_d, st_q;
    logic [2:0]    new_tags;
    logic          ovw_head;
    logic [CW-1:0] cnt_n;

    always_comb begin
        st_d     = st_q;
        new_tags = (rx_valid_i && !st_q.rep) ? head_tags_i : 3'b000;
        ovw_head = rx_ovw_i && (rx_count_i == CW'(1));

        cnt_n = st_q.err_cnt;
        if (rx_pushed_i && |in_tags_i)   cnt_n = cnt_n + CW'(1);
        if (rx_popped_i && |head_tags_i) cnt_n = cnt_n - CW'(1);
        if (rx_ovw_i) begin
            if (|last_tags_i && !(|in_tags_i)) cnt_n = cnt_n - CW'(1);
            if (!(|last_tags_i) && |in_tags_i) cnt_n = cnt_n + CW'(1);
        end
        if (flush_i) cnt_n = '0;
        st_d.err_cnt = cnt_n;

        st_d.oe  = (lsr_rd_i ? 1'b0 : st_q.oe) | rx_ovw_i;
        st_d.pe  = (lsr_rd_i ? 1'b0 : st_q.pe) | new_tags[0];
        st_d.fe  = (lsr_rd_i ? 1'b0 : st_q.fe) | new_tags[1];
        st_d.bi  = (lsr_rd_i ? 1'b0 : st_q.bi) | new_tags[2];
        st_d.sum = (cnt_n != '0) | (st_q.sum & !lsr_rd_i);
        st_d.rep = (flush_i || rx_popped_i || ovw_head) ? 1'b0 : (st_q.rep | rx_valid_i);
        if (flush_i) begin
            st_d.pe  = 1'b0;
            st_d.fe  = 1'b0;
            st_d.bi  = 1'b0;
            st_d.sum = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lsr_o = {st_q.sum & fifo_mode_i, tx_empty_i, tx_empty_i,
                    st_q.bi, st_q.fe, st_q.pe, st_q.oe, rx_valid_i};
    assign irq_o = (ier_thre_i & tx_empty_i) |
                   (ier_rls_i & (st_q.oe | st_q.pe | st_q.fe | st_q.bi));

    // R7: an overwrite always leaves the overrun flag set
    a_r7_oe_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_ovw_i |=> st_q.oe) else $error("R7 overrun lost");
    // R12: a status read without a same-edge overrun clears the flag
    a_r12_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsr_rd_i && !rx_ovw_i |=> !st_q.oe) else $error("R12 overrun not cleared");
    // R8: tags of an already reported head are not shown again
    a_r8_shown_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lsr_rd_i && st_q.rep && !rx_popped_i && !rx_ovw_i && !flush_i
        |=> !st_q.pe && !st_q.fe && !st_q.bi) else $error("R8 tag repeated");
endmodule

// File: rtl/uhb_bridge.sv
module uhb_bridge
    import uhb_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_ior_ni,
    input  logic              host_iow_ni,
    input  logic              host_aen_ni,
    input  logic [OFS_W-1:0]  host_addr_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] host_rdata_o,
    output logic              host_irq_o,
    input  logic              ctl_rx_push_i,
    input  logic [BYTE_W-1:0] ctl_rx_data_i,
    input  logic              ctl_rx_pe_i,
    input  logic              ctl_rx_fe_i,
    input  logic              ctl_rx_bi_i,
    input  logic              ctl_tx_pop_i,
    output logic [BYTE_W-1:0] ctl_tx_data_o,
    output logic              ctl_tx_valid_o,
    output logic              ctl_dtr_no,
    output logic              ctl_rts_no
);
    localparam int unsigned AW   = $clog2(DEPTH);
    localparam int unsigned CW   = AW + 1;
    localparam int unsigned RX_W = $bits(rx_ent_t);

    typedef struct packed {
        logic ier_thre;
        logic ier_rls;
        logic fifo_mode;
        logic dtr;
        logic rts;
    } ctl_st_t;

    ctl_st_t  ctl_d, ctl_q;
    host_op_t op;

    logic [CW-1:0]     cap;
    logic              flush, rx_pop, tx_push, lsr_rd;
    rx_ent_t           rx_in, rx_head, rx_last;
    logic              rx_empty, rx_full, rx_pushed, rx_popped, rx_ovw;
    logic [CW-1:0]     rx_count;
    logic [BYTE_W-1:0] tx_head, tx_last;
    logic              tx_empty, tx_full, tx_pushed, tx_popped, tx_ovw;
    logic [CW-1:0]     tx_count;
    logic [7:0]        lsr;
    logic              sig_unused;

    uhb_host_if u_host (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ior_ni  (host_ior_ni),
        .iow_ni  (host_iow_ni),
        .aen_ni  (host_aen_ni),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .op_o    (op)
    );

    always_comb begin
        cap     = ctl_q.fifo_mode ? CW'(DEPTH) : CW'(1);
        flush   = op.wr && (op.ofs == OFS_MODE);
        tx_push = op.wr && (op.ofs == OFS_DATA);
        rx_pop  = op.rd && (op.ofs == OFS_DATA);
        lsr_rd  = op.rd && (op.ofs == OFS_LSTAT);
        rx_in   = '{bi: ctl_rx_bi_i, fe: ctl_rx_fe_i, pe: ctl_rx_pe_i, data: ctl_rx_data_i};
    end

    always_comb begin
        ctl_d = ctl_q;
        if (op.wr) begin
            case (op.ofs)
                OFS_IEN: begin
                    ctl_d.ier_thre = op.wdata[1];
                    ctl_d.ier_rls  = op.wdata[2];
                end
                OFS_MODE: ctl_d.fifo_mode = op.wdata[0];
                OFS_MCTL: begin
                    ctl_d.dtr = op.wdata[0];
                    ctl_d.rts = op.wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    uhb_fifo #(.W(RX_W), .DEPTH(DEPTH), .OVERWRITE(1'b1)) u_rxq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flush_i  (flush),
        .cap_i    (cap),
        .push_i   (ctl_rx_push_i),
        .din_i    (rx_in),
        .pop_i    (rx_pop),
        .head_o   (rx_head),
        .last_o   (rx_last),
        .empty_o  (rx_empty),
        .full_o   (rx_full),
        .count_o  (rx_count),
        .pushed_o (rx_pushed),
        .popped_o (rx_popped),
        .ovw_o    (rx_ovw)
    );

    uhb_fifo #(.W(BYTE_W), .DEPTH(DEPTH), .OVERWRITE(1'b0)) u_txq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .flush_i  (flush),
        .cap_i    (cap),
        .push_i   (tx_push),
        .din_i    (op.wdata),
        .pop_i    (ctl_tx_pop_i),
        .head_o   (tx_head),
        .last_o   (tx_last),
        .empty_o  (tx_empty),
        .full_o   (tx_full),
        .count_o  (tx_count),
        .pushed_o (tx_pushed),
        .popped_o (tx_popped),
        .ovw_o    (tx_ovw)
    );

    uhb_lsr #(.DEPTH(DEPTH)) u_lsr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush),
        .fifo_mode_i (ctl_q.fifo_mode),
        .lsr_rd_i    (lsr_rd),
        .rx_valid_i  (!rx_empty),
        .rx_count_i  (rx_count),
        .head_tags_i ({rx_head.bi, rx_head.fe, rx_head.pe}),
        .in_tags_i   ({rx_in.bi, rx_in.fe, rx_in.pe}),
        .last_tags_i ({rx_last.bi, rx_last.fe, rx_last.pe}),
        .rx_pushed_i (rx_pushed),
        .rx_popped_i (rx_popped),
        .rx_ovw_i    (rx_ovw),
        .tx_empty_i  (tx_empty),
        .ier_thre_i  (ctl_q.ier_thre),
        .ier_rls_i   (ctl_q.ier_rls),
        .lsr_o       (lsr),
        .irq_o       (host_irq_o)
    );

    always_comb begin
        host_rdata_o = '0;
        if (!host_ior_ni && !host_aen_ni) begin
            case (host_addr_i)
                OFS_DATA:  host_rdata_o = rx_empty ? 8'h00 : rx_head.data;
                OFS_IEN:   host_rdata_o = {5'b0, ctl_q.ier_rls, ctl_q.ier_thre, 1'b0};
                OFS_MODE:  host_rdata_o = {7'b0, ctl_q.fifo_mode};
                OFS_MCTL:  host_rdata_o = {6'b0, ctl_q.rts, ctl_q.dtr};
                OFS_LSTAT: host_rdata_o = lsr;
                default:   host_rdata_o = '0;
            endcase
        end
    end

    assign ctl_tx_data_o  = tx_head;
    assign ctl_tx_valid_o = !tx_empty;
    assign ctl_dtr_no     = !ctl_q.dtr;
    assign ctl_rts_no     = !ctl_q.rts;

    assign sig_unused = ^{rx_full, tx_last, tx_full, tx_count, tx_pushed, tx_popped, tx_ovw};

    // R2: a modem-control write lands inverted on the controller pins
    a_r2_dtr_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op.wr && (op.ofs == OFS_MCTL) |=> ctl_dtr_no == !$past(op.wdata[0]))
        else $error("R2 terminal-ready level");
    a_r2_rts_inverted: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op.wr && (op.ofs == OFS_MCTL) |=> ctl_rts_no == !$past(op.wdata[1]))
        else $error("R2 request-to-send level");
    // R5: transmit byte offered exactly when the status shows not empty
    a_r5_empty_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_tx_valid_o |-> !lsr[5] && !lsr[6]) else $error("R5 empty flags");
endmodule

// File: tb/uhb_bridge_tb.sv
`timescale 1ns/1ps
module uhb_bridge_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ior_n = 1'b1, iow_n = 1'b1, aen_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       rx_push = 1'b0, rx_pe = 1'b0, rx_fe = 1'b0, rx_bi = 1'b0;
    logic [7:0] rx_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid, dtr_n, rts_n;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    uhb_bridge #(.DEPTH(16)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .host_ior_ni(ior_n), .host_iow_ni(iow_n), .host_aen_ni(aen_n),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
        .host_irq_o(irq),
        .ctl_rx_push_i(rx_push), .ctl_rx_data_i(rx_data),
        .ctl_rx_pe_i(rx_pe), .ctl_rx_fe_i(rx_fe), .ctl_rx_bi_i(rx_bi),
        .ctl_tx_pop_i(tx_pop), .ctl_tx_data_o(tx_data), .ctl_tx_valid_o(tx_valid),
        .ctl_dtr_no(dtr_n), .ctl_rts_no(rts_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; aen_n = 1'b0; ior_n = 1'b0;
        #1 d = rdata;
        @(negedge clk);
        ior_n = 1'b1; aen_n = 1'b1;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d, input logic en = 1'b1);
        @(negedge clk);
        addr = a; wdata = d; aen_n = !en; iow_n = 1'b0;
        @(negedge clk);
        iow_n = 1'b1; aen_n = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        host_rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic push_rx(input logic [7:0] d, input logic [2:0] tags);
        @(negedge clk);
        rx_data = d; {rx_bi, rx_fe, rx_pe} = tags; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0; {rx_bi, rx_fe, rx_pe} = 3'b000;
    endtask

    task automatic pop_tx(output logic [7:0] d);
        @(negedge clk);
        d = tx_data; tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 3'd5, 8'h60);
        rd_chk("R1 modem ctl", 3'd4, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 tx valid", {7'b0, tx_valid}, 8'h00);
        chk("R1 pins", {6'b0, rts_n, dtr_n}, 8'h03);
    endtask

    task automatic t_mcr;
        host_wr(3'd4, 8'hFF);
        rd_chk("R2 upper bits zero", 3'd4, 8'h03);
        chk("R2 both pins low", {6'b0, rts_n, dtr_n}, 8'h00);
        host_wr(3'd4, 8'h02);
        chk("R2 rts low dtr high", {6'b0, rts_n, dtr_n}, 8'h01);
        host_wr(3'd4, 8'h00, 1'b0);
        rd_chk("R3 enable high ignored", 3'd4, 8'h02);
        host_wr(3'd4, 8'h00);
        chk("R2 pins released", {6'b0, rts_n, dtr_n}, 8'h03);
    endtask

    task automatic t_char_tx;
        logic [7:0] d;
        host_wr(3'd0, 8'hA1);
        host_wr(3'd0, 8'hA2);
        chk("R4 char mode valid", {7'b0, tx_valid}, 8'h01);
        rd_chk("R5 not empty", 3'd5, 8'h00);
        pop_tx(d);
        chk("R4 char mode keeps first", d, 8'hA1);
        chk("R4 second dropped", {7'b0, tx_valid}, 8'h00);
        rd_chk("R5 empty again", 3'd5, 8'h60);
    endtask

    task automatic t_char_rx;
        push_rx(8'h5A, 3'b000);
        push_rx(8'h5B, 3'b000);
        rd_chk("R7 char mode overrun", 3'd5, 8'h63);
        rd_chk("R6 returns overwrite", 3'd0, 8'h5B);
        rd_chk("R7 overrun cleared", 3'd5, 8'h60);
        push_rx(8'h33, 3'b001);
        rd_chk("R9 char mode bit7 zero", 3'd5, 8'h65);
        rd_chk("R8 parity shown once", 3'd5, 8'h61);
        rd_chk("R6 data", 3'd0, 8'h33);
    endtask

    task automatic t_fifo_tx;
        logic [7:0] d;
        host_wr(3'd2, 8'h01);
        rd_chk("R10 mode bit", 3'd2, 8'h01);
        for (int i = 0; i < 17; i++) host_wr(3'd0, 8'h10 + 8'(i));
        rd_chk("R5 queue not empty", 3'd5, 8'h00);
        for (int i = 0; i < 16; i++) begin
            pop_tx(d);
            chk("R4 transmit order", d, 8'h10 + 8'(i));
        end
        chk("R4 seventeenth dropped", {7'b0, tx_valid}, 8'h00);
        rd_chk("R5 queue drained", 3'd5, 8'h60);
    endtask

    task automatic t_fifo_rx;
        logic [7:0] d;
        push_rx(8'hC0, 3'b000);
        push_rx(8'hC1, 3'b000);
        push_rx(8'hC2, 3'b000);
        rd_chk("R6 data ready", 3'd5, 8'h61);
        rd_chk("R6 order 0", 3'd0, 8'hC0);
        rd_chk("R6 order 1", 3'd0, 8'hC1);
        rd_chk("R6 order 2", 3'd0, 8'hC2);
        rd_chk("R6 ready cleared", 3'd5, 8'h60);
        rd_chk("R6 empty read", 3'd0, 8'h00);
        push_rx(8'hD0, 3'b000);
        push_rx(8'hD1, 3'b000);
        @(negedge clk);
        addr = 3'd0; aen_n = 1'b0; ior_n = 1'b0;
        #1 d = rdata;
        chk("R3 held read data", d, 8'hD0);
        idle(4);
        ior_n = 1'b1; aen_n = 1'b1;
        rd_chk("R3 held read pops once", 3'd0, 8'hD1);
        rd_chk("R3 queue empty", 3'd5, 8'h60);
    endtask

    task automatic t_overrun;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) push_rx(8'h40 + 8'(i), 3'b000);
        rd_chk("R7 full no overrun", 3'd5, 8'h61);
        push_rx(8'hEE, 3'b000);
        rd_chk("R7 overrun set", 3'd5, 8'h63);
        @(negedge clk);
        addr = 3'd5; aen_n = 1'b0; ior_n = 1'b0;
        rx_data = 8'hEF; rx_push = 1'b1;
        #1 d = rdata;
        chk("R12 read before same-edge overrun", d, 8'h61);
        @(negedge clk);
        ior_n = 1'b1; aen_n = 1'b1; rx_push = 1'b0;
        rd_chk("R12 same-edge overrun kept", 3'd5, 8'h63);
        host_wr(3'd5, 8'hFF);
        rd_chk("R12 status write ignored", 3'd5, 8'h61);
        for (int i = 0; i < 15; i++) rd_chk("R7 older entries kept", 3'd0, 8'h40 + 8'(i));
        rd_chk("R7 newest replaced", 3'd0, 8'hEF);
        rd_chk("R7 drained", 3'd5, 8'h60);
    endtask

    task automatic t_tags;
        push_rx(8'hD0, 3'b000);
        push_rx(8'hD1, 3'b001);
        push_rx(8'hD2, 3'b010);
        rd_chk("R9 summary while tagged queued", 3'd5, 8'hE1);
        rd_chk("R9 summary persists", 3'd5, 8'hE1);
        rd_chk("R6 clean head", 3'd0, 8'hD0);
        rd_chk("R8 parity at head", 3'd5, 8'hE5);
        rd_chk("R8 parity not repeated", 3'd5, 8'hE1);
        rd_chk("R6 parity char", 3'd0, 8'hD1);
        rd_chk("R8 framing at head", 3'd5, 8'hE9);
        rd_chk("R6 framing char", 3'd0, 8'hD2);
        rd_chk("R9 summary until read", 3'd5, 8'hE0);
        rd_chk("R9 summary cleared", 3'd5, 8'h60);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        host_wr(3'd2, 8'h01);
        host_wr(3'd1, 8'h02);
        rd_chk("R11 enable readback", 3'd1, 8'h02);
        chk("R11 empty irq", {7'b0, irq}, 8'h01);
        host_wr(3'd0, 8'h77);
        chk("R11 irq drops on write", {7'b0, irq}, 8'h00);
        pop_tx(d);
        chk("R4 popped", d, 8'h77);
        chk("R11 irq on empty", {7'b0, irq}, 8'h01);
        host_wr(3'd1, 8'h04);
        chk("R11 status irq idle", {7'b0, irq}, 8'h00);
        push_rx(8'h88, 3'b100);
        idle(1);
        chk("R11 break raises irq", {7'b0, irq}, 8'h01);
        rd_chk("R8 break shown", 3'd5, 8'hF1);
        chk("R11 irq cleared by read", {7'b0, irq}, 8'h00);
        rd_chk("R6 break char", 3'd0, 8'h88);
        host_wr(3'd0, 8'h55);
        host_wr(3'd2, 8'h01);
        chk("R10 write flushes tx", {7'b0, tx_valid}, 8'h00);
        host_wr(3'd1, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mcr();
        t_char_tx();
        t_char_rx();
        t_fifo_tx();
        t_fifo_rx();
        t_overrun();
        t_tags();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule